// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two 8-bit two's-complement operands and returns their full 16-bit two's-complement product in a single combinational pass. The multiplier operand is recoded into four radix-4 signed digits, each drawn from {-2, -1, 0, +1, +2}. Each digit selects a scaled and possibly negated copy of the multiplicand as a partial product, and the four partial products are added at their weights.

Every digit has its own recoder and its own partial-product generator. Each generator produces a 9-bit partial product. Negation is done by bitwise inversion followed by a ripple of half adders that adds the one. A separate sign bit comes out of that ripple, so the one product that needs a tenth bit is still exact. The partial products are sign-extended and shifted by two bit positions per digit, then summed by a chain of adders. Each adder in the chain spans only the bits its partial product can reach.

The operand width is a parameter (default 8, must be even). There is no clock and no state. The block is meant to sit inside a larger datapath where the surrounding registers set its timing.

Top module: `booth_mult`

## Requirements
- R1: For every pair of operands, `prod` equals the 16-bit two's-complement value of `mcand` times `mplier`, both read as signed.
- R2: Digit i is formed from the multiplier bit triple (bit 2i+1, bit 2i, bit 2i-1), with bit -1 taken as 0. Its value is -2·b(2i+1) + b(2i) + b(2i-1).
- R3: Each recoded digit asserts exactly one of the controls zero, single and double. Negate is asserted only when the digit is nonzero. The triples 000 and 111 both give zero without negate.
- R4: A zero digit yields an all-zero partial product with a clear sign bit, whatever the multiplicand.
- R5: A negative digit yields exactly -A or -2A by inversion plus increment. This includes -2 times -128 = +256, which needs the separate sign bit, and the negation of a zero multiplicand.
- R6: Partial product i is sign-extended to the product width and added at weight 4^i. A multiplier equal to ±4^i therefore gives ±A·4^i.
- R7: -13 (11110011) times -95 (10100001) gives 1235 (0000010011010011).
- R8: The extreme operands give exact results: -128·-128 = 16384, -128·127 = -16256, 127·127 = 16129.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 8 | Signed multiplicand |
| mplier | input | 8 | Signed multiplier, recoded into radix-4 digits |
| prod | output | 16 | Signed product |

## Verification
The bench sweeps all 65,536 operand pairs against arithmetic done in the bench. It also drives directed cases aimed at the recoding and negation corners. With a multiplicand of one, every multiplier value passes straight through, which exposes any wrong triple decode. A wrongly weighted or wrongly extended partial product shows up under multipliers of ±4^i. A generator that reads the sign from the ninth bit would turn -128·-128 into -16384. A 111 triple that sets negate, or a zero multiplicand whose increment carry is lost, would leave a stray sign that corrupts the upper product bits.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Radix-4 digit controls: exactly one of zero/single/double is set,
    // neg only accompanies a nonzero magnitude.
    typedef struct packed {
        logic zero;
        logic single;
        logic double;
        logic neg;
    } digit_ctl_t;

    // Signed value of a recoded digit, used by checks.
    function automatic int digit_value(input digit_ctl_t d);
        int mag;
        mag = d.single ? 1 : (d.double ? 2 : 0);
        return d.neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/booth_encoder.sv
module booth_encoder
    import booth_pkg::*;
(
    input  logic [2:0]  triple,   // {b(2i+1), b(2i), b(2i-1)}
    output digit_ctl_t  dig
);

    always_comb begin
        dig = '0;
        unique case (triple)
            3'b000, 3'b111: dig.zero   = 1'b1;
            3'b001, 3'b010: dig.single = 1'b1;
            3'b011:         dig.double = 1'b1;
            3'b100: begin
                dig.double = 1'b1;
                dig.neg    = 1'b1;
            end
            3'b101, 3'b110: begin
                dig.single = 1'b1;
                dig.neg    = 1'b1;
            end
            default: dig.zero = 1'b1;
        endcase
    end

    always_comb begin
        // R3
        ctl_onehot_chk: assert ($onehot({dig.zero, dig.single, dig.double}))
            else $error("R3: digit controls not one-hot");
        // R3
        neg_nonzero_chk: assert (!(dig.neg && dig.zero))
            else $error("R3: negate with zero digit");
        // R2
        digit_value_chk: assert (digit_value(dig) ==
                                 -2 * int'(triple[2]) + int'(triple[1]) + int'(triple[0]))
            else $error("R2: digit value mismatch");
    end

endmodule

// File: rtl/booth_decoder.sv
module booth_decoder
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] mcand,
    input  digit_ctl_t     dig,
    output logic [OPW:0]   pp,       // 9-bit partial product at default width
    output logic           pp_sign   // true sign of the partial product
);

    localparam int PPW = OPW + 1;

    logic [PPW-1:0] mag;
    logic [PPW-1:0] flip;
    logic [PPW:0]   carry;

    always_comb begin
        if (dig.single)      mag = {mcand[OPW-1], mcand};
        else if (dig.double) mag = {mcand, 1'b0};
        else                 mag = '0;
        flip = mag ^ {PPW{dig.neg}};
    end

    assign carry[0] = dig.neg;

    // Half-adder increment ripple completing the two's-complement negation.
    for (genvar k = 0; k < PPW; k++) begin : g_ha
        assign pp[k]      = flip[k] ^ carry[k];
        assign carry[k+1] = flip[k] & carry[k];
    end

    // Sign of the 10-bit negation: inverted extension bit plus final carry.
    assign pp_sign = dig.neg ? (~mag[PPW-1] ^ carry[PPW]) : mag[PPW-1];

    always_comb begin
        // R4
        zero_pp_chk: assert (!dig.zero || (pp == '0 && !pp_sign))
            else $error("R4: zero digit gave nonzero partial product");
        // R5
        pp_value_chk: assert (int'($signed({pp_sign, pp})) ==
                              digit_value(dig) * int'($signed(mcand)))
            else $error("R5: partial product value wrong");
    end

endmodule

// File: rtl/booth_accum.sv
module booth_accum #(
    parameter int OPW = 8
) (
    input  logic [OPW/2-1:0][OPW:0] pp,
    input  logic [OPW/2-1:0]        pp_sign,
    output logic [2*OPW-1:0]        prod
);

    localparam int NDIG = OPW / 2;
    localparam int PPW  = OPW + 1;
    localparam int PW   = 2 * OPW;

    logic [PW-1:0] acc [NDIG+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < NDIG; i++) begin : g_stage
        localparam int SH = 2 * i;
        localparam int AW = PW - SH;
        logic [AW-1:0] ext;
        // Sign-extension unit: widen to the remaining product span.
        assign ext = {{(AW-PPW){pp_sign[i]}}, pp[i]};
        if (i == 0) begin : g_first
            assign acc[i+1] = acc[i] + ext;
        end else begin : g_rest
            // Bits below the weight are final; the adder covers the rest.
            assign acc[i+1] = {acc[i][PW-1:SH] + ext, acc[i][SH-1:0]};
        end
    end

    assign prod = acc[NDIG];

endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0]   mcand,
    input  logic [OPW-1:0]   mplier,
    output logic [2*OPW-1:0] prod
);

    localparam int NDIG = OPW / 2;
    localparam int PW   = 2 * OPW;

    logic [OPW:0]              mplier_x;
    digit_ctl_t                dig [NDIG];
    logic [NDIG-1:0][OPW:0]    pp;
    logic [NDIG-1:0]           pp_sign;

    // Append the implicit zero below bit 0.
    assign mplier_x = {mplier, 1'b0};

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        booth_encoder i_enc (
            .triple (mplier_x[2*i+2:2*i]),
            .dig    (dig[i])
        );
        booth_decoder #(.OPW(OPW)) i_dec (
            .mcand   (mcand),
            .dig     (dig[i]),
            .pp      (pp[i]),
            .pp_sign (pp_sign[i])
        );
    end

    booth_accum #(.OPW(OPW)) i_accum (
        .pp      (pp),
        .pp_sign (pp_sign),
        .prod    (prod)
    );

    always_comb begin
        // R1
        product_chk: assert (prod == PW'(longint'($signed(mcand)) * longint'($signed(mplier))))
            else $error("R1: product mismatch");
    end

endmodule

// File: tb/test_booth_mult.sv
module test_booth_mult;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic [7:0]  mcand = '0;
    logic [7:0]  mplier = '0;
    logic [15:0] prod;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    booth_mult #(.OPW(8)) i_booth_mult (
        .mcand  (mcand),
        .mplier (mplier),
        .prod   (prod)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Drive at the rising edge, compare at the falling edge.
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input int expv,
                         input string req);
        @(posedge clk);
        mcand  = a;
        mplier = b;
        @(negedge clk);
        n_checks++;
        if (int'($signed(prod)) != expv) begin
            n_fail++;
            $display("FAIL %s: a=%0d b=%0d actual %0d expected %0d", req,
                     $signed(a), $signed(b), $signed(prod), expv);
        end
    endtask

    function automatic int smul(input logic [7:0] a, input logic [7:0] b);
        return int'($signed(a)) * int'($signed(b));
    endfunction

    initial begin
        // Idle operands: product at rest is zero (R1)
        apply(8'h00, 8'h00, 0, "R1");

        // R7: the worked signed example
        apply(8'b11110011, 8'b10100001, 1235, "R7");

        // R8: extremes
        apply(8'h80, 8'h80, 16384, "R8");
        apply(8'h80, 8'h7F, -16256, "R8");
        apply(8'h7F, 8'h80, -16256, "R8");
        apply(8'h7F, 8'h7F, 16129, "R8");

        // R2: unit multiplicand passes every multiplier value through
        for (int b = 0; b < 256; b++)
            apply(8'h01, 8'(b), int'($signed(8'(b))), "R2");

        // R3: all-ones multiplier leaves only digit 0 active at -1
        for (int a = 0; a < 256; a += 17)
            apply(8'(a), 8'hFF, -int'($signed(8'(a))), "R3");

        // R4: zero multiplier, all digits zero
        for (int a = 0; a < 256; a += 5)
            apply(8'(a), 8'h00, 0, "R4");

        // R5: negation corners, including -2 x -128 and -1 x 0
        apply(8'h80, 8'h02, -256, "R5");
        apply(8'h80, 8'hFE, 256, "R5");
        apply(8'h00, 8'hAA, 0, "R5");
        apply(8'h01, 8'h80, -128, "R5");

        // R6: single-digit weights +-4^i
        for (int i = 0; i < 4; i++) begin
            for (int a = 0; a < 256; a += 51) begin
                apply(8'(a), 8'(1 << (2*i)), int'($signed(8'(a))) * (1 << (2*i)), "R6");
                apply(8'(a), 8'(-(1 << (2*i))), -int'($signed(8'(a))) * (1 << (2*i)), "R6");
            end
        end

        // R1: exhaustive sweep
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply(8'(a), 8'(b), smul(8'(a), 8'(b)), "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule